// File: doc/BRIEF.md
# Radix-2 FFT Operand Address Sequencer

This block steers a single butterfly unit through a 16-point, in-place, radix-2 transform. A `start` pulse launches a job. For every butterfly the block then presents an address pair, a twiddle index, the current stage and an end-of-stage flag. The pair is an upper and a lower address into the working memory. Results go back to the same pair, so one memory holds the whole transform. The arithmetic, the memories and the table of eight twiddle constants all live outside the block.

The block has two job types, chosen by `reorder_mode` at launch. The transform job walks four passes of eight butterflies each. The address pattern comes from a butterfly counter and a span register. The span register changes only at a pass boundary. The reorder job walks all sixteen indices and pairs each index with its bit-reversed partner, so data can be moved into natural order.

The operand interface is a stream. `op_valid` marks a live operand set and `op_ready` accepts it. While `op_valid` is high and `op_ready` is low, every operand output holds its value. A set is consumed only in a cycle where both are high. `done` pulses once after the last set of a job is consumed.

Top module: `r2_fft_agu`

## Requirements
- R1: After reset `op_valid` and `done` are low.
- R2: A `start` seen while `op_valid` is low raises `op_valid` on the next cycle. The first set is stage 0, upper 0, lower 8 (transform) or upper 0, lower 0 (reorder), with twiddle 0.
- R3: In transform stage s (0..3) with butterfly count b (0..7), the upper address is b with a 0 inserted at bit position 3-s. The lower address is the upper address plus 8>>s.
- R4: In the transform job the twiddle index is (b<<s) mod 8.
- R5: A transform job presents stages 0,1,2,3 in order, eight butterflies each, b rising from 0 to 7. `stage_last` is high exactly on b=7.
- R6: While `op_valid` is high and `op_ready` is low, the next cycle still has `op_valid` high, and the addresses, twiddle index, stage and `stage_last` are unchanged.
- R7: `done` is high for exactly one cycle: the cycle after the final set of a job is consumed. In that cycle `op_valid` is low.
- R8: `op_ready` while idle has no effect. `start` and `reorder_mode` while `op_valid` is high have no effect, including a `start` in the cycle of the final handshake.
- R9: In the reorder job, set i (0..15) has upper address i and lower address equal to i with its four bits reversed (3 gives 12). Twiddle and stage read 0, `stage_last` is high on i=15, and `done` follows the 16th handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a job when idle |
| reorder_mode | input | 1 | Job type sampled with start: 0 transform, 1 reorder |
| op_ready | input | 1 | Consumer accepts the present operand set |
| op_valid | output | 1 | Operand set present |
| addr_upper | output | 4 | Upper (first) memory address |
| addr_lower | output | 4 | Lower (second) memory address |
| tw_idx | output | 3 | Twiddle table index |
| stage | output | 2 | Current pass number |
| stage_last | output | 1 | Present set ends its pass |
| done | output | 1 | One-cycle job completion pulse |

## Verification
Two functions can fall in the same cycle: a job's final handshake and a new `start`. The bench provokes this by driving `start` together with the accepting `op_ready` on the last set. It then drives `start` again in the `done` cycle. The first `start` must leave `op_valid` low beside a single `done` pulse. The second must open a fresh job whose first set is stage 0, pair (0,8), and every set that follows is compared against the bench's reference loop.

// File: rtl/r2_fft_agu_pkg.sv
package r2_fft_agu_pkg;

  typedef enum logic {
    JOB_XFORM  = 1'b0,
    JOB_REORDER = 1'b1
  } job_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_e;

endpackage

// File: rtl/agu_sequencer.sv
module agu_sequencer
  import r2_fft_agu_pkg::*;
#(
  parameter int LOG2N = 4,
  localparam int BW = LOG2N - 1,
  localparam int SW = (LOG2N > 1) ? $clog2(LOG2N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             reorder_mode,
  input  logic             op_ready,
  output logic             running,
  output job_e             job,
  output logic [LOG2N-1:0] cnt,
  output logic [SW-1:0]    pass,
  output logic [LOG2N-1:0] span,
  output logic             bfly_wrap,
  output logic             idx_wrap,
  output logic             done
);

  localparam int STAGES = LOG2N;

  seq_e             state_q;
  job_e             job_q;
  logic [LOG2N-1:0] cnt_q;
  logic [SW-1:0]    pass_q;
  logic [LOG2N-1:0] span_q;
  logic             done_q;

  logic fire;
  logic last_pass;
  logic final_beat;

  assign bfly_wrap  = &cnt_q[BW-1:0];
  assign idx_wrap   = &cnt_q;
  assign last_pass  = (pass_q == SW'(STAGES - 1));
  assign fire       = (state_q == SEQ_RUN) && op_ready;
  assign final_beat = fire && ((job_q == JOB_REORDER) ? idx_wrap
                                                      : (bfly_wrap && last_pass));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      job_q   <= JOB_XFORM;
      cnt_q   <= '0;
      pass_q  <= '0;
      span_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == SEQ_IDLE) begin
        if (start) begin
          state_q <= SEQ_RUN;
          job_q   <= reorder_mode ? JOB_REORDER : JOB_XFORM;
          cnt_q   <= '0;
          pass_q  <= '0;
          span_q  <= LOG2N'(1) << (LOG2N - 1);
        end
      end else if (fire) begin
        if (final_beat) begin
          state_q <= SEQ_IDLE;
          done_q  <= 1'b1;
          cnt_q   <= '0;
          pass_q  <= '0;
        end else if (job_q == JOB_XFORM && bfly_wrap) begin
          cnt_q  <= '0;
          pass_q <= pass_q + 1'b1;
          span_q <= span_q >> 1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign running = (state_q == SEQ_RUN);
  assign job     = job_q;
  assign cnt     = cnt_q;
  assign pass    = pass_q;
  assign span    = span_q;
  assign done    = done_q;

endmodule

// File: rtl/agu_pair_gen.sv
module agu_pair_gen #(
  parameter int LOG2N = 4,
  localparam int BW = LOG2N - 1
) (
  input  logic [BW-1:0]    bfly,
  input  logic [LOG2N-1:0] span,
  output logic [LOG2N-1:0] upper,
  output logic [LOG2N-1:0] lower
);

  logic [LOG2N-1:0] wide;
  logic [LOG2N-1:0] low_mask;

  assign wide     = {1'b0, bfly};
  assign low_mask = span - 1'b1;
  assign upper    = ((wide & ~low_mask) << 1) | (wide & low_mask);
  assign lower    = upper | span;

endmodule

// File: rtl/agu_twiddle.sv
module agu_twiddle #(
  parameter int LOG2N = 4,
  localparam int BW = LOG2N - 1,
  localparam int SW = (LOG2N > 1) ? $clog2(LOG2N) : 1
) (
  input  logic [BW-1:0] bfly,
  input  logic [SW-1:0] pass,
  output logic [BW-1:0] tw
);

  localparam int STAGES = LOG2N;

  logic [BW-1:0] cand [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_shift
    assign cand[g] = bfly << g;
  end

  always_comb begin
    tw = '0;
    for (int g = 0; g < STAGES; g++) begin
      if (pass == SW'(g)) tw = cand[g];
    end
  end

endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int W = 4
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign dout[i] = din[W-1-i];
  end

endmodule

// File: rtl/r2_fft_agu.sv
module r2_fft_agu
  import r2_fft_agu_pkg::*;
#(
  parameter int LOG2N = 4,
  localparam int BW = LOG2N - 1,
  localparam int SW = (LOG2N > 1) ? $clog2(LOG2N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             reorder_mode,
  input  logic             op_ready,
  output logic             op_valid,
  output logic [LOG2N-1:0] addr_upper,
  output logic [LOG2N-1:0] addr_lower,
  output logic [BW-1:0]    tw_idx,
  output logic [SW-1:0]    stage,
  output logic             stage_last,
  output logic             done
);

  logic             running;
  job_e             job;
  logic [LOG2N-1:0] cnt;
  logic [SW-1:0]    pass;
  logic [LOG2N-1:0] span;
  logic             bfly_wrap;
  logic             idx_wrap;
  logic [LOG2N-1:0] xf_upper;
  logic [LOG2N-1:0] xf_lower;
  logic [BW-1:0]    xf_tw;
  logic [LOG2N-1:0] rev_idx;
  logic             reorder;

  agu_sequencer #(.LOG2N(LOG2N)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .reorder_mode (reorder_mode),
    .op_ready     (op_ready),
    .running      (running),
    .job          (job),
    .cnt          (cnt),
    .pass         (pass),
    .span         (span),
    .bfly_wrap    (bfly_wrap),
    .idx_wrap     (idx_wrap),
    .done         (done)
  );

  agu_pair_gen #(.LOG2N(LOG2N)) u_pair (
    .bfly  (cnt[BW-1:0]),
    .span  (span),
    .upper (xf_upper),
    .lower (xf_lower)
  );

  agu_twiddle #(.LOG2N(LOG2N)) u_tw (
    .bfly (cnt[BW-1:0]),
    .pass (pass),
    .tw   (xf_tw)
  );

  agu_bitrev #(.W(LOG2N)) u_rev (
    .din  (cnt),
    .dout (rev_idx)
  );

  assign reorder    = (job == JOB_REORDER);
  assign op_valid   = running;
  assign addr_upper = reorder ? cnt     : xf_upper;
  assign addr_lower = reorder ? rev_idx : xf_lower;
  assign tw_idx     = reorder ? '0      : xf_tw;
  assign stage      = reorder ? '0      : pass;
  assign stage_last = reorder ? idx_wrap : bfly_wrap;

endmodule

// File: rtl/r2_fft_agu_checker.sv
module r2_fft_agu_checker #(
  parameter int LOG2N = 4,
  localparam int BW = LOG2N - 1,
  localparam int SW = (LOG2N > 1) ? $clog2(LOG2N) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             op_ready,
  input logic             op_valid,
  input logic [LOG2N-1:0] addr_upper,
  input logic [LOG2N-1:0] addr_lower,
  input logic [BW-1:0]    tw_idx,
  input logic [SW-1:0]    stage,
  input logic             stage_last,
  input logic             done,
  input logic             reorder
);

  // R6: operand set frozen under back-pressure
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(addr_upper) && $stable(addr_lower)
                              && $stable(tw_idx) && $stable(stage) && $stable(stage_last));

  // R7: done follows a consumed final set and coincides with op_valid low
  a_r7_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !op_valid && $past(op_valid && op_ready && stage_last));

  // R7: done never lasts two cycles
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: transform pair differs in exactly one bit, upper below lower
  a_r3_pair_split: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !reorder |-> ($countones(addr_upper ^ addr_lower) == 1)
                             && (addr_upper < addr_lower));

  // R5: pass advances by one after its last butterfly is consumed
  a_r5_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && stage_last && !reorder && (stage != SW'(LOG2N - 1))
    |=> op_valid && (stage == SW'($past(stage) + 1'b1)));

  // R8: without start, an idle block stays idle
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && !start |=> !op_valid);

  // R9: reorder sets carry zero twiddle and stage
  a_r9_reorder_fields: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && reorder |-> (tw_idx == '0) && (stage == '0));

endmodule

bind r2_fft_agu r2_fft_agu_checker #(.LOG2N(LOG2N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .op_ready   (op_ready),
  .op_valid   (op_valid),
  .addr_upper (addr_upper),
  .addr_lower (addr_lower),
  .tw_idx     (tw_idx),
  .stage      (stage),
  .stage_last (stage_last),
  .done       (done),
  .reorder    (reorder)
);

// File: tb/tb_r2_fft_agu.sv
`timescale 1ns/1ps
module tb_r2_fft_agu;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       reorder_mode = 1'b0;
  logic       op_ready = 1'b0;
  logic       op_valid;
  logic [3:0] addr_upper;
  logic [3:0] addr_lower;
  logic [2:0] tw_idx;
  logic [1:0] stage;
  logic       stage_last;
  logic       done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  r2_fft_agu dut (
    .clk(clk), .rst_n(rst_n), .start(start), .reorder_mode(reorder_mode),
    .op_ready(op_ready), .op_valid(op_valid), .addr_upper(addr_upper),
    .addr_lower(addr_lower), .tw_idx(tw_idx), .stage(stage),
    .stage_last(stage_last), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_upper(input bit md, input int k);
    int s, b, p;
    if (md) return k;
    s = k / 8; b = k % 8; p = 3 - s;
    return ((b >> p) << (p + 1)) | (b & ((1 << p) - 1));
  endfunction

  function automatic int ref_lower(input bit md, input int k);
    int r;
    if (md) begin
      r = 0;
      for (int i = 0; i < 4; i++) if ((k >> i) & 1) r |= 1 << (3 - i);
      return r;
    end
    return ref_upper(md, k) + (8 >> (k / 8));
  endfunction

  function automatic int ref_tw(input bit md, input int k);
    if (md) return 0;
    return ((k % 8) << (k / 8)) % 8;
  endfunction

  function automatic int ref_stage(input bit md, input int k);
    return md ? 0 : k / 8;
  endfunction

  function automatic int ref_last(input bit md, input int k);
    return md ? int'(k == 15) : int'((k % 8) == 7);
  endfunction

  task automatic launch(input bit md);
    @(negedge clk);
    start = 1'b1; reorder_mode = md; op_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Walks one job; tail=1 drives start on the final handshake and again in the done cycle
  task automatic beats(input bit md, input int pct, input bit tail);
    int total = md ? 16 : 32;
    int k = 0;
    bit rdy;
    while (k < total) begin
      chk("R2/R6 op_valid", op_valid, 1);
      chk(md ? "R9 upper" : "R3 upper", addr_upper, ref_upper(md, k));
      chk(md ? "R9 lower" : "R3 lower", addr_lower, ref_lower(md, k));
      chk(md ? "R9 twiddle" : "R4 twiddle", tw_idx, ref_tw(md, k));
      chk(md ? "R9 stage" : "R5 stage", stage, ref_stage(md, k));
      chk(md ? "R9 stage_last" : "R5 stage_last", stage_last, ref_last(md, k));
      chk("R7 no early done", done, 0);
      rdy = (($urandom % 100) < pct);
      start = (($urandom % 6) == 0);          // R8: ignored while busy
      reorder_mode = 1'($urandom);            // R8: ignored while busy
      if (tail && k == total - 1) begin
        start = 1'b1; rdy = 1'b1;
      end
      op_ready = rdy;
      @(negedge clk);
      if (rdy) k++;
    end
    chk("R7/R8 op_valid low in done cycle", op_valid, 0);
    chk("R7 done pulse", done, 1);
    if (tail) begin
      start = 1'b1; reorder_mode = md; op_ready = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk("R7 done single", done, 0);
    end else begin
      start = 1'b0; op_ready = 1'b0;
      @(negedge clk);
      chk("R7 done single", done, 0);
      chk("R8 stays idle", op_valid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1 op_valid after reset", op_valid, 0);
    chk("R1 done after reset", done, 0);
    rst_n = 1'b1;

    op_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 ready while idle", op_valid, 0);
      chk("R8 no done while idle", done, 0);
    end
    op_ready = 1'b0;

    launch(1'b0);
    chk("R2 first pair upper", addr_upper, 0);
    chk("R2 first pair lower", addr_lower, 8);
    beats(1'b0, 100, 1'b0);

    launch(1'b0);
    beats(1'b0, 50, 1'b1);
    chk("R2 restart from done cycle", op_valid, 1);
    chk("R2 restart upper", addr_upper, 0);
    chk("R2 restart lower", addr_lower, 8);
    beats(1'b0, 70, 1'b0);

    launch(1'b1);
    chk("R9 first set lower", addr_lower, 0);
    beats(1'b1, 60, 1'b0);

    launch(1'b0);
    beats(1'b0, 25, 1'b0);

    for (int j = 0; j < 6; j++) begin
      bit md = 1'($urandom);
      int pct = 20 + int'($urandom % 81);
      launch(md);
      beats(md, pct, 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule